// File: doc/BRIEF.md
# PIO Sector Transfer Controller

This block is a single-channel programmed-I/O disk controller core reached through a byte-wide register bus. Software loads a small set of task-file registers: sector count, a 28-bit starting sector split over four bytes, and a drive-select bit. It then issues a read or a write command. The data moves one sector at a time through an internal sector buffer. The host fills the buffer for a write and empties it for a read, always through a single data register.

Toward storage, the block raises a request carrying the direction, the drive and the sector address. While that request is pending, the storage side reads or writes the sector buffer through its own byte port, then pulses an acknowledge.

Each buffer phase is followed by a busy phase. The busy phase ends once a programmable ready delay has run out and storage has finished. On leaving the busy phase the controller raises a maskable completion interrupt.

Top module: `pio_sector_ctrl`

## Requirements
- R1: After reset the status byte reads 0x40, the error register reads 0x00, and both `irq_o` and `stor_req_o` are low.
- R2: Register offsets:
  - 2 to 6 hold sector count, sector, address-low, address-high and drive/head. Each reads back the last value written.
  - Offset 1 reads the error register; writes to offset 1 change nothing readable.
  - Offset 7 reads status and takes commands when written.
  - Offset 8 reads an alternate copy of status and takes device control when written.
- R3: Command codes:
  - 0x20 and 0x21 start a read; 0x30 and 0x31 start a write.
  - Any other code is ignored.
  - A command written while the controller is not idle is ignored.
- R4: A sector count of 0 transfers 256 sectors; otherwise exactly the count is transferred.
- R5: Storage addressing:
  - The first sector address is {drive/head[3:0], address-high, address-low, sector}.
  - Each request to storage uses the next address in sequence.
  - `stor_drive_o` carries drive/head bit 4.
- R6: Read command:
  - The controller immediately requests a priming fetch and shows busy.
  - When busy ends it enters the draining phase (status 0x08) and the interrupt is raised.
  - Bytes then read from offset 0 are the fetched sector, in buffer order.
- R7: Write data path:
  - Each full sector written at offset 0 in the loading phase is committed with one write request.
  - During that request, storage reads the bytes back from the buffer in the order they were written.
- R8: Busy phase exit:
  - A busy phase ends at the first edge at which the delay counter (loaded with `ready_delay_i` on entry) is zero and no storage request is outstanding. A delay of D therefore gives at least D+1 busy cycles, and exactly one cycle for D=0 with no request.
  - It then returns to loading or draining if sectors remain, or to idle otherwise.
  - The interrupt is raised in both cases.
- R9: The status byte is 0x08 while loading or draining, 0x80 while busy, and 0x40 when idle.
- R10: Reading offset 7 clears a pending interrupt. Reading offset 8 does not.
- R11: While device-control bit 1 is 1, the interrupt is not raised. Writing device control with bit 1 set clears a pending interrupt.
- R12: Protocol error:
  - A data-port read outside draining, or a data-port write outside loading, sets error-register bit 0 and leaves the phase unchanged.
  - The bit stays set until the next accepted command clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 4 | Register offset |
| bus_rd_i | input | 1 | Read strobe (side effects at the clock edge) |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the current offset (combinational) |
| ready_delay_i | input | DELAY_W | Busy delay in cycles, sampled on entry to a busy phase |
| irq_o | output | 1 | Completion interrupt |
| stor_req_o | output | 1 | Storage request, held until acknowledged |
| stor_write_o | output | 1 | 1 = commit buffer to storage, 0 = fetch into buffer |
| stor_drive_o | output | 1 | Selected drive |
| stor_lba_o | output | 28 | Sector address of the request |
| stor_ack_i | input | 1 | One-cycle acknowledge from storage |
| stor_baddr_i | input | POS_W | Storage-side buffer byte address |
| stor_bwe_i | input | 1 | Storage-side buffer write enable (honoured only during a fetch) |
| stor_bwdata_i | input | 8 | Storage-side buffer write data |
| stor_brdata_o | output | 8 | Buffer byte at `stor_baddr_i` |

## Verification
The embedded properties watch the invariants that hold on every cycle:
- a storage request exists only inside a busy phase;
- a host phase never runs with zero sectors left;
- a busy phase ends only on an expired delay;
- the delay counter steps down by one;
- the interrupt only rises while unmasked;
- an alternate-status read never drops it;
- the error bit only falls on a command.

The bench scenarios show what no single-cycle property can: the exact busy lengths for a long delay and a zero delay, the priming fetch before the first read byte, the sector address sequence and buffer contents seen by storage, the 256-sector meaning of a zero count, and which register reads clear the interrupt.

// File: rtl/pio_xfer_pkg.sv
package pio_xfer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_BUSY_LOAD  = 3'd1,
        ST_BUSY_DRAIN = 3'd2,
        ST_BUSY_DMA   = 3'd3,
        ST_BUSY_CMD   = 3'd4,
        ST_LOAD       = 3'd5,
        ST_DRAIN      = 3'd6
    } xfer_state_e;

    localparam logic [7:0] STAT_READY = 8'h40;
    localparam logic [7:0] STAT_BUSY  = 8'h80;
    localparam logic [7:0] STAT_DRQ   = 8'h08;

    localparam logic [3:0] OFS_DATA   = 4'd0;
    localparam logic [3:0] OFS_ERR    = 4'd1;
    localparam logic [3:0] OFS_COUNT  = 4'd2;
    localparam logic [3:0] OFS_SECT   = 4'd3;
    localparam logic [3:0] OFS_ADDR_L = 4'd4;
    localparam logic [3:0] OFS_ADDR_H = 4'd5;
    localparam logic [3:0] OFS_DH     = 4'd6;
    localparam logic [3:0] OFS_STAT   = 4'd7;
    localparam logic [3:0] OFS_CTRL   = 4'd8;

    localparam logic [7:0] CMD_RD_A = 8'h20;
    localparam logic [7:0] CMD_RD_B = 8'h21;
    localparam logic [7:0] CMD_WR_A = 8'h30;
    localparam logic [7:0] CMD_WR_B = 8'h31;

    localparam int LBA_W = 28;

endpackage

// File: rtl/pio_sector_buf.sv
module pio_sector_buf #(
    parameter int DEPTH = 16
) (
    input  logic                     clk_i,
    input  logic                     we_i,
    input  logic [$clog2(DEPTH)-1:0] waddr_i,
    input  logic [7:0]               wdata_i,
    input  logic [$clog2(DEPTH)-1:0] raddr_a_i,
    input  logic [$clog2(DEPTH)-1:0] raddr_b_i,
    output logic [7:0]               rdata_a_o,
    output logic [7:0]               rdata_b_o
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk_i) begin
            if (we_i && waddr_i == AW'(g)) begin
                mem_q[g] <= wdata_i;
            end
        end
    end

    assign rdata_a_o = mem_q[raddr_a_i];
    assign rdata_b_o = mem_q[raddr_b_i];

endmodule

// File: rtl/pio_ready_timer.sv
module pio_ready_timer #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         done_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = value_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);

    // R8: the busy delay counts down one step per cycle when not reloaded
    assert_count_down_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!load_i && cnt_q != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pio_sector_ctrl.sv
module pio_sector_ctrl
    import pio_xfer_pkg::*;
#(
    parameter int SECTOR_BYTES = 16,
    parameter int DELAY_W      = 16,
    parameter int POS_W        = $clog2(SECTOR_BYTES)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [3:0]         bus_addr_i,
    input  logic               bus_rd_i,
    input  logic               bus_wr_i,
    input  logic [7:0]         bus_wdata_i,
    output logic [7:0]         bus_rdata_o,
    input  logic [DELAY_W-1:0] ready_delay_i,
    output logic               irq_o,
    output logic               stor_req_o,
    output logic               stor_write_o,
    output logic               stor_drive_o,
    output logic [27:0]        stor_lba_o,
    input  logic               stor_ack_i,
    input  logic [POS_W-1:0]   stor_baddr_i,
    input  logic               stor_bwe_i,
    input  logic [7:0]         stor_bwdata_i,
    output logic [7:0]         stor_brdata_o
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(SECTOR_BYTES - 1);

    typedef struct packed {
        xfer_state_e      state;
        logic [8:0]       remain;
        logic [POS_W-1:0] pos;
        logic [LBA_W-1:0] next_lba;
        logic [LBA_W-1:0] req_lba;
        logic             req;
        logic             req_wr;
        logic             drive;
        logic             err;
        logic             irq;
        logic             mask;
        logic [7:0]       cnt;
        logic [7:0]       sect;
        logic [7:0]       addr_l;
        logic [7:0]       addr_h;
        logic [7:0]       dh;
    } ctrl_t;

    ctrl_t q_q, q_d;
    logic  timer_load, timer_done;
    logic  host_we;
    logic  buf_we;
    logic [POS_W-1:0] buf_waddr;
    logic [7:0] buf_wdata, host_rbyte;
    logic  in_busy;
    logic [7:0] status_byte;

    assign in_busy = (q_q.state == ST_BUSY_LOAD) || (q_q.state == ST_BUSY_DRAIN);

    always_comb begin
        unique case (q_q.state)
            ST_IDLE:            status_byte = STAT_READY;
            ST_LOAD, ST_DRAIN:  status_byte = STAT_DRQ;
            default:            status_byte = STAT_BUSY;
        endcase
    end

    always_comb begin
        q_d        = q_q;
        timer_load = 1'b0;
        host_we    = 1'b0;

        if (bus_wr_i) begin
            unique case (bus_addr_i)
                OFS_COUNT:  q_d.cnt    = bus_wdata_i;
                OFS_SECT:   q_d.sect   = bus_wdata_i;
                OFS_ADDR_L: q_d.addr_l = bus_wdata_i;
                OFS_ADDR_H: q_d.addr_h = bus_wdata_i;
                OFS_DH:     q_d.dh     = bus_wdata_i;
                OFS_CTRL: begin
                    q_d.mask = bus_wdata_i[1];
                    if (bus_wdata_i[1]) q_d.irq = 1'b0;
                end
                OFS_STAT: begin
                    if (q_q.state == ST_IDLE &&
                        (bus_wdata_i == CMD_RD_A || bus_wdata_i == CMD_RD_B ||
                         bus_wdata_i == CMD_WR_A || bus_wdata_i == CMD_WR_B)) begin
                        q_d.remain   = (q_q.cnt == 8'd0) ? 9'd256 : {1'b0, q_q.cnt};
                        q_d.next_lba = {q_q.dh[3:0], q_q.addr_h, q_q.addr_l, q_q.sect};
                        q_d.drive    = q_q.dh[4];
                        q_d.err      = 1'b0;
                        q_d.pos      = '0;
                        if (bus_wdata_i[4]) begin
                            q_d.state = ST_LOAD;
                        end else begin
                            q_d.req      = 1'b1;
                            q_d.req_wr   = 1'b0;
                            q_d.req_lba  = {q_q.dh[3:0], q_q.addr_h, q_q.addr_l, q_q.sect};
                            q_d.next_lba = {q_q.dh[3:0], q_q.addr_h, q_q.addr_l, q_q.sect} + 1'b1;
                            q_d.state    = ST_BUSY_DRAIN;
                            timer_load   = 1'b1;
                        end
                    end
                end
                OFS_DATA: begin
                    if (q_q.state == ST_LOAD) begin
                        host_we = 1'b1;
                        if (q_q.pos == LAST_POS) begin
                            q_d.pos      = '0;
                            q_d.req      = 1'b1;
                            q_d.req_wr   = 1'b1;
                            q_d.req_lba  = q_q.next_lba;
                            q_d.next_lba = q_q.next_lba + 1'b1;
                            q_d.remain   = q_q.remain - 1'b1;
                            q_d.state    = ST_BUSY_LOAD;
                            timer_load   = 1'b1;
                        end else begin
                            q_d.pos = q_q.pos + 1'b1;
                        end
                    end else begin
                        q_d.err = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        if (bus_rd_i) begin
            if (bus_addr_i == OFS_STAT) begin
                q_d.irq = 1'b0;
            end else if (bus_addr_i == OFS_DATA) begin
                if (q_q.state == ST_DRAIN) begin
                    if (q_q.pos == LAST_POS) begin
                        q_d.pos    = '0;
                        q_d.remain = q_q.remain - 1'b1;
                        q_d.state  = ST_BUSY_DRAIN;
                        timer_load = 1'b1;
                        if (q_q.remain > 9'd1) begin
                            q_d.req      = 1'b1;
                            q_d.req_wr   = 1'b0;
                            q_d.req_lba  = q_q.next_lba;
                            q_d.next_lba = q_q.next_lba + 1'b1;
                        end
                    end else begin
                        q_d.pos = q_q.pos + 1'b1;
                    end
                end else begin
                    q_d.err = 1'b1;
                end
            end
        end

        if (q_q.req && stor_ack_i) begin
            q_d.req = 1'b0;
        end

        if (in_busy && timer_done && (!q_q.req || stor_ack_i)) begin
            if (q_q.remain == 9'd0)              q_d.state = ST_IDLE;
            else if (q_q.state == ST_BUSY_LOAD)  q_d.state = ST_LOAD;
            else                                 q_d.state = ST_DRAIN;
            if (!q_q.mask) q_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= '{state: ST_IDLE, default: '0};
        else         q_q <= q_d;
    end

    assign buf_we    = host_we || (stor_bwe_i && q_q.req && !q_q.req_wr);
    assign buf_waddr = host_we ? q_q.pos : stor_baddr_i;
    assign buf_wdata = host_we ? bus_wdata_i : stor_bwdata_i;

    pio_sector_buf #(.DEPTH(SECTOR_BYTES)) u_buf (
        .clk_i     (clk_i),
        .we_i      (buf_we),
        .waddr_i   (buf_waddr),
        .wdata_i   (buf_wdata),
        .raddr_a_i (q_q.pos),
        .raddr_b_i (stor_baddr_i),
        .rdata_a_o (host_rbyte),
        .rdata_b_o (stor_brdata_o)
    );

    pio_ready_timer #(.W(DELAY_W)) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (timer_load),
        .value_i (ready_delay_i),
        .done_o  (timer_done)
    );

    always_comb begin
        unique case (bus_addr_i)
            OFS_DATA:           bus_rdata_o = (q_q.state == ST_DRAIN) ? host_rbyte : 8'h00;
            OFS_ERR:            bus_rdata_o = {7'd0, q_q.err};
            OFS_COUNT:          bus_rdata_o = q_q.cnt;
            OFS_SECT:           bus_rdata_o = q_q.sect;
            OFS_ADDR_L:         bus_rdata_o = q_q.addr_l;
            OFS_ADDR_H:         bus_rdata_o = q_q.addr_h;
            OFS_DH:             bus_rdata_o = q_q.dh;
            OFS_STAT, OFS_CTRL: bus_rdata_o = status_byte;
            default:            bus_rdata_o = 8'h00;
        endcase
    end

    assign irq_o        = q_q.irq;
    assign stor_req_o   = q_q.req;
    assign stor_write_o = q_q.req_wr;
    assign stor_drive_o = q_q.drive;
    assign stor_lba_o   = q_q.req_lba;

    // R7: storage is only asked for a sector inside a busy phase
    assert_req_in_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stor_req_o |-> (q_q.state == ST_BUSY_LOAD || q_q.state == ST_BUSY_DRAIN));

    // R4: a host buffer phase always has at least one sector left
    assert_host_phase_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q_q.state == ST_LOAD || q_q.state == ST_DRAIN) |-> (q_q.remain != 9'd0));

    // R8: leaving a busy phase requires an expired delay
    assert_busy_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(in_busy) && !in_busy) |-> $past(timer_done));

    // R11: the interrupt rises only while unmasked
    assert_irq_unmasked_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> !$past(q_q.mask));

    // R10: reading the alternate status keeps a pending interrupt
    assert_alt_keeps_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(irq_o && bus_rd_i && !bus_wr_i && bus_addr_i == OFS_CTRL) |-> irq_o);

    // R12: the protocol error bit falls only on a command accepted in idle
    assert_err_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(q_q.err) |-> $past(bus_wr_i && bus_addr_i == OFS_STAT && q_q.state == ST_IDLE));

endmodule

// File: tb/pio_sector_ctrl_tb.sv
module pio_sector_ctrl_tb;
    import pio_xfer_pkg::*;

    localparam int SB = 16;
    localparam int PW = $clog2(SB);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] delay = '0;
    logic        irq, sreq, swr, sdrive;
    logic        sack = 1'b0, sbwe = 1'b0;
    logic [27:0] slba;
    logic [PW-1:0] sbaddr = '0;
    logic [7:0]  sbwdata = '0;
    logic [7:0]  sbrdata;

    int errors = 0, checks = 0;
    int commits = 0, fetches = 0;
    logic [27:0] exp_lba = '0;
    logic        exp_drive = 1'b0;
    logic        finished = 1'b0;

    always #5 clk = ~clk;

    pio_sector_ctrl #(.SECTOR_BYTES(SB), .DELAY_W(16)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_rd_i(rd), .bus_wr_i(wr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ready_delay_i(delay), .irq_o(irq),
        .stor_req_o(sreq), .stor_write_o(swr), .stor_drive_o(sdrive), .stor_lba_o(slba),
        .stor_ack_i(sack), .stor_baddr_i(sbaddr), .stor_bwe_i(sbwe),
        .stor_bwdata_i(sbwdata), .stor_brdata_o(sbrdata)
    );

    function automatic logic [7:0] wpat(input logic [27:0] l, input int i);
        return (l[7:0] * 8'd13 + 8'(i)) ^ 8'hA5;
    endfunction

    function automatic logic [7:0] rpat(input logic [27:0] l, input int i);
        return l[7:0] * 8'd29 + 8'(i) + 8'h3C;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bwr(input logic [3:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic brd(input logic [3:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        addr = OFS_CTRL;
        #1;
        while (rdata == STAT_BUSY && n < 5000) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    // storage model: serves each request through the buffer port, then acknowledges
    initial begin : storage_model
        logic [27:0] l;
        forever begin
            @(negedge clk);
            if (rst_n && sreq) begin
                l = slba;
                chk("R5", "request sector", slba, exp_lba);
                chk("R5", "request drive", sdrive, exp_drive);
                exp_lba = exp_lba + 1'b1;
                for (int i = 0; i < SB; i++) begin
                    sbaddr = PW'(i);
                    if (swr) begin
                        #1 chk("R7", "committed byte", sbrdata, wpat(l, i));
                    end else begin
                        sbwe = 1'b1;
                        sbwdata = rpat(l, i);
                    end
                    @(negedge clk);
                end
                if (swr) commits++; else fetches++;
                sbwe = 1'b0;
                sack = 1'b1;
                @(negedge clk);
                sack = 1'b0;
            end
        end
    end

    typedef struct packed {
        logic       is_wr;
        logic [3:0] a;
        logic [7:0] v;
    } vec_t;

    localparam vec_t VECS [14] = '{
        '{1'b1, 4'd2, 8'h05}, '{1'b1, 4'd3, 8'hA1}, '{1'b1, 4'd4, 8'hB2},
        '{1'b1, 4'd5, 8'hC3}, '{1'b1, 4'd6, 8'h5E}, '{1'b0, 4'd2, 8'h05},
        '{1'b0, 4'd3, 8'hA1}, '{1'b0, 4'd4, 8'hB2}, '{1'b0, 4'd5, 8'hC3},
        '{1'b0, 4'd6, 8'h5E}, '{1'b1, 4'd1, 8'hFF}, '{1'b0, 4'd1, 8'h00},
        '{1'b0, 4'd8, 8'h40}, '{1'b0, 4'd7, 8'h40}
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        int n, sectors, c0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(OFS_STAT, d); chk("R1", "status after reset", d, 8'h40);
        peek(OFS_ERR, d);  chk("R1", "error after reset", d, 8'h00);
        chk("R1", "irq after reset", irq, 1'b0);
        chk("R1", "request after reset", sreq, 1'b0);

        // R2 register map table
        foreach (VECS[k]) begin
            if (VECS[k].is_wr) bwr(VECS[k].a, VECS[k].v);
            else begin
                brd(VECS[k].a, d);
                chk("R2", $sformatf("offset %0d readback", VECS[k].a), d, VECS[k].v);
            end
        end

        // R12 data read while idle
        brd(OFS_DATA, d);
        peek(OFS_ERR, d);  chk("R12", "error after idle data read", d, 8'h01);
        peek(OFS_CTRL, d); chk("R12", "phase after idle data read", d, 8'h40);

        // R3 unknown command ignored
        bwr(OFS_STAT, 8'h50);
        peek(OFS_CTRL, d); chk("R3", "status after unknown command", d, 8'h40);
        peek(OFS_ERR, d);  chk("R3", "error kept after unknown command", d, 8'h01);

        // write of two sectors, drive 1, start sector 0x10
        delay = 16'd40;
        bwr(OFS_COUNT, 8'd2); bwr(OFS_SECT, 8'h10); bwr(OFS_ADDR_L, 8'h00);
        bwr(OFS_ADDR_H, 8'h00); bwr(OFS_DH, 8'h50);
        exp_lba = 28'h10; exp_drive = 1'b1;
        bwr(OFS_STAT, 8'h31);
        peek(OFS_CTRL, d); chk("R3", "loading after write command", d, 8'h08);
        peek(OFS_ERR, d);  chk("R12", "error cleared by command", d, 8'h00);
        for (int i = 0; i < SB / 2; i++) bwr(OFS_DATA, wpat(28'h10, i));
        bwr(OFS_STAT, 8'h20);
        peek(OFS_CTRL, d); chk("R3", "command ignored while loading", d, 8'h08);
        for (int i = SB / 2; i < SB; i++) bwr(OFS_DATA, wpat(28'h10, i));
        wait_ready(n);
        chk("R8", "busy cycles with delay 40", n, 41);
        chk("R8", "irq after first sector", irq, 1'b1);
        brd(OFS_STAT, d); chk("R9", "status in loading", d, 8'h08);
        chk("R10", "status read clears irq", irq, 1'b0);
        for (int i = 0; i < SB; i++) bwr(OFS_DATA, wpat(28'h11, i));
        wait_ready(n);
        peek(OFS_CTRL, d); chk("R8", "idle after last sector", d, 8'h40);
        chk("R8", "irq on final completion", irq, 1'b1);
        chk("R7", "commit count", commits, 2);
        chk("R5", "sector sequence advanced", exp_lba, 28'h12);
        brd(OFS_CTRL, d);
        chk("R10", "alternate status keeps irq", irq, 1'b1);
        brd(OFS_STAT, d);
        chk("R10", "status read clears irq", irq, 1'b0);

        // read of two sectors, drive 0, start sector 0x20
        delay = 16'd3;
        bwr(OFS_COUNT, 8'd2); bwr(OFS_SECT, 8'h20); bwr(OFS_DH, 8'h40);
        exp_lba = 28'h20; exp_drive = 1'b0;
        bwr(OFS_STAT, 8'h20);
        peek(OFS_CTRL, d); chk("R6", "busy right after read command", d, 8'h80);
        wait_ready(n);
        peek(OFS_CTRL, d); chk("R6", "draining after priming fetch", d, 8'h08);
        chk("R6", "irq after priming fetch", irq, 1'b1);
        chk("R6", "priming fetch issued", fetches, 1);
        brd(OFS_STAT, d);
        bwr(OFS_DATA, 8'hEE);
        peek(OFS_ERR, d);  chk("R12", "error after write while draining", d, 8'h01);
        peek(OFS_CTRL, d); chk("R12", "phase kept after bad write", d, 8'h08);
        for (int i = 0; i < SB; i++) begin
            brd(OFS_DATA, d);
            chk("R6", $sformatf("sector 0x20 byte %0d", i), d, rpat(28'h20, i));
        end
        wait_ready(n);
        peek(OFS_CTRL, d); chk("R6", "draining second sector", d, 8'h08);
        chk("R6", "second fetch issued", fetches, 2);
        delay = 16'd0;
        for (int i = 0; i < SB; i++) begin
            brd(OFS_DATA, d);
            chk("R6", $sformatf("sector 0x21 byte %0d", i), d, rpat(28'h21, i));
        end
        wait_ready(n);
        chk("R8", "busy cycles with delay 0", n, 1);
        peek(OFS_CTRL, d); chk("R9", "status idle", d, 8'h40);
        chk("R8", "irq after final drain", irq, 1'b1);
        brd(OFS_STAT, d);

        // R11 masking
        bwr(OFS_CTRL, 8'h02);
        delay = 16'd2;
        bwr(OFS_COUNT, 8'd1); bwr(OFS_SECT, 8'h30);
        exp_lba = 28'h30;
        bwr(OFS_STAT, 8'h20);
        wait_ready(n);
        peek(OFS_CTRL, d); chk("R11", "draining while masked", d, 8'h08);
        chk("R11", "irq held low while masked", irq, 1'b0);
        bwr(OFS_CTRL, 8'h00);
        for (int i = 0; i < SB; i++) brd(OFS_DATA, d);
        wait_ready(n);
        chk("R11", "irq after unmask", irq, 1'b1);
        bwr(OFS_CTRL, 8'h02);
        chk("R11", "control write clears irq", irq, 1'b0);
        bwr(OFS_CTRL, 8'h00);

        // R4 count of zero means 256 sectors
        delay = 16'd0;
        bwr(OFS_COUNT, 8'd0); bwr(OFS_SECT, 8'h00); bwr(OFS_ADDR_L, 8'h00);
        bwr(OFS_ADDR_H, 8'h00); bwr(OFS_DH, 8'h40);
        exp_lba = 28'h0; exp_drive = 1'b0;
        c0 = commits;
        sectors = 0;
        bwr(OFS_STAT, 8'h30);
        for (int s = 0; s < 300; s++) begin
            for (int i = 0; i < SB; i++) bwr(OFS_DATA, wpat(28'(s), i));
            wait_ready(n);
            sectors++;
            peek(OFS_CTRL, d);
            if (d == 8'h40) break;
        end
        chk("R4", "sectors for count 0", sectors, 256);
        chk("R4", "commits for count 0", commits - c0, 256);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule